// File: doc/BRIEF.md
# Multi-Context Register Bank

This block holds several complete copies of a small architectural register set, one copy per hardware context, so that a core can move from one thread to another by changing a context number instead of saving and restoring registers. Each context owns four general registers; a stack-pointer register sits beside them. A build-time switch chooses whether the stack pointer is copied into every context or kept as a single register that all contexts share.

There is one write port and two read ports. Every port carries its own context number, so a cycle may read from one context while it writes to another. This is the pattern an interleaved pipeline produces, where the decode stage and the write-back stage belong to different threads. Reads are combinational from the stored state. Writes land on the rising clock edge and are never forwarded to a read in the same cycle. The selection of contexts and any bypassing stay with the surrounding pipeline.

Top module: `ctx_regbank`

## Requirements
- R1: An active-low reset sets every general register of every context, and every stack-pointer copy, to zero.
- R2: With `wr_en`=1 and `wr_sp`=0, `wr_data` is stored in general register `wr_addr` of context `wr_ctx` on the rising edge. A read of that context and address in the following cycle returns it.
- R3: A general-register write changes no register of any context other than `wr_ctx`, including the same address in the other contexts.
- R4: With `wr_en`=0, no register changes, whatever the other write inputs are.
- R5: The two read ports select independently. In one cycle they may return different contexts and addresses.
- R6: A read in the same cycle as a write to the same context and address returns the value held before that edge. There is no forwarding.
- R7: The read context and the write context are independent inputs. A write to one context does not alter, in that cycle, what a read of another context returns.
- R8: With `SP_SHARED`=0, a write with `wr_sp`=1 updates only the stack pointer of `wr_ctx`. A read with `rdX_sp`=1 returns the stack pointer of `rdX_ctx` and ignores `rdX_addr`.
- R9: With `SP_SHARED`=1, there is one stack pointer. A write from any context is returned by stack-pointer reads from every context.
- R10: A stack-pointer write (`wr_sp`=1, `wr_addr` ignored) leaves every general register unchanged. A general-register write leaves every stack pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_sp | input | 1 | 1: write targets the stack pointer; 0: a general register |
| wr_ctx | input | 2 | Context of the write |
| wr_addr | input | 2 | General register index of the write |
| wr_data | input | DATA_W | Write data |
| rda_sp | input | 1 | Port A reads the stack pointer when 1 |
| rda_ctx | input | 2 | Context read by port A |
| rda_addr | input | 2 | Register index read by port A |
| rda_data | output | DATA_W | Port A read data |
| rdb_sp | input | 1 | Port B reads the stack pointer when 1 |
| rdb_ctx | input | 2 | Context read by port B |
| rdb_addr | input | 2 | Register index read by port B |
| rdb_data | output | DATA_W | Port B read data |

## Verification
A read and a write can fall in the same cycle, either on the same context and address or on different contexts. The bench provokes both from a vector table. Each vector drives a write together with two reads. The reads are sampled after the inputs settle and before the edge, and each must give the old contents; the next vector then confirms that the write landed only where it was aimed. A second instance built with a shared stack pointer gets the same stimulus, and its stack-pointer reads from all contexts are compared with the replicated instance.

// File: rtl/ctx_regbank_pkg.sv
package ctx_regbank_pkg;

    // Which kind of register a port addresses
    typedef enum logic {
        TGT_GPR = 1'b0,
        TGT_SP  = 1'b1
    } reg_tgt_e;

endpackage

// File: rtl/ctx_gpr_bank.sv
module ctx_gpr_bank #(
    parameter  int DATA_W   = 32,
    parameter  int NUM_CTX  = 4,
    parameter  int NUM_REGS = 4,
    localparam int CTX_W    = (NUM_CTX  > 1) ? $clog2(NUM_CTX)  : 1,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                                          clk_i,
    input  logic                                          rst_ni,
    input  logic                                          we_i,
    input  logic [CTX_W-1:0]                              wctx_i,
    input  logic [ADDR_W-1:0]                             waddr_i,
    input  logic [DATA_W-1:0]                             wdata_i,
    output logic [NUM_CTX-1:0][NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

    typedef struct packed {
        logic [NUM_CTX-1:0][NUM_REGS-1:0][DATA_W-1:0] regs;
    } gpr_state_t;

    gpr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.regs[wctx_i][waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;

    // Idle write port leaves every context untouched
    p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(st_q.regs));

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_iso
        // A write aimed elsewhere leaves this context alone
        p_ctx_isolate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && (wctx_i != CTX_W'(c))) |=> $stable(st_q.regs[c]));
    end

endmodule

// File: rtl/ctx_sp_bank.sv
module ctx_sp_bank #(
    parameter  int DATA_W    = 32,
    parameter  int NUM_CTX   = 4,
    parameter  bit SHARED    = 1'b0,
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             we_i,
    input  logic [CTX_W-1:0]                 wctx_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_CTX-1:0][DATA_W-1:0]   sp_o
);

    if (SHARED) begin : g_shared
        typedef struct packed {
            logic [DATA_W-1:0] sp;
        } sp_state_t;

        sp_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (we_i) begin
                st_d.sp = wdata_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        for (genvar c = 0; c < NUM_CTX; c++) begin : g_fan
            assign sp_o[c] = st_q.sp;
        end

        logic unused_ctx;
        assign unused_ctx = ^wctx_i;
    end else begin : g_repl
        typedef struct packed {
            logic [NUM_CTX-1:0][DATA_W-1:0] sp;
        } sp_state_t;

        sp_state_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (we_i) begin
                st_d.sp[wctx_i] = wdata_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign sp_o = st_q.sp;

        for (genvar c = 0; c < NUM_CTX; c++) begin : g_iso
            // Each context keeps its own stack pointer
            p_sp_isolate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !(we_i && (wctx_i == CTX_W'(c))) |=> $stable(st_q.sp[c]));
        end
    end

endmodule

// File: rtl/ctx_read_port.sv
module ctx_read_port
    import ctx_regbank_pkg::*;
#(
    parameter  int DATA_W   = 32,
    parameter  int NUM_CTX  = 4,
    parameter  int NUM_REGS = 4,
    localparam int CTX_W    = (NUM_CTX  > 1) ? $clog2(NUM_CTX)  : 1,
    localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [NUM_CTX-1:0][NUM_REGS-1:0][DATA_W-1:0]  regs_i,
    input  logic [NUM_CTX-1:0][DATA_W-1:0]                sp_i,
    input  reg_tgt_e                                      tgt_i,
    input  logic [CTX_W-1:0]                              ctx_i,
    input  logic [ADDR_W-1:0]                             addr_i,
    output logic [DATA_W-1:0]                             data_o
);

    always_comb begin
        if (tgt_i == TGT_SP) begin
            data_o = sp_i[ctx_i];
        end else begin
            data_o = regs_i[ctx_i][addr_i];
        end
    end

endmodule

// File: rtl/ctx_regbank.sv
module ctx_regbank
    import ctx_regbank_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int NUM_CTX   = 4,
    parameter  int NUM_REGS  = 4,
    parameter  bit SP_SHARED = 1'b0,
    localparam int CTX_W     = (NUM_CTX  > 1) ? $clog2(NUM_CTX)  : 1,
    localparam int ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sp,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rda_sp,
    input  logic [CTX_W-1:0]  rda_ctx,
    input  logic [ADDR_W-1:0] rda_addr,
    output logic [DATA_W-1:0] rda_data,
    input  logic              rdb_sp,
    input  logic [CTX_W-1:0]  rdb_ctx,
    input  logic [ADDR_W-1:0] rdb_addr,
    output logic [DATA_W-1:0] rdb_data
);

    logic [NUM_CTX-1:0][NUM_REGS-1:0][DATA_W-1:0] regs_w;
    logic [NUM_CTX-1:0][DATA_W-1:0]               sp_w;
    reg_tgt_e                                     wr_tgt;
    logic                                         gpr_we, sp_we;

    assign wr_tgt = reg_tgt_e'(wr_sp);
    assign gpr_we = wr_en && (wr_tgt == TGT_GPR);
    assign sp_we  = wr_en && (wr_tgt == TGT_SP);

    ctx_gpr_bank #(
        .DATA_W   (DATA_W),
        .NUM_CTX  (NUM_CTX),
        .NUM_REGS (NUM_REGS)
    ) gpr_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .we_i    (gpr_we),
        .wctx_i  (wr_ctx),
        .waddr_i (wr_addr),
        .wdata_i (wr_data),
        .regs_o  (regs_w)
    );

    ctx_sp_bank #(
        .DATA_W  (DATA_W),
        .NUM_CTX (NUM_CTX),
        .SHARED  (SP_SHARED)
    ) sp_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .we_i    (sp_we),
        .wctx_i  (wr_ctx),
        .wdata_i (wr_data),
        .sp_o    (sp_w)
    );

    ctx_read_port #(
        .DATA_W   (DATA_W),
        .NUM_CTX  (NUM_CTX),
        .NUM_REGS (NUM_REGS)
    ) rda_i (
        .regs_i (regs_w),
        .sp_i   (sp_w),
        .tgt_i  (reg_tgt_e'(rda_sp)),
        .ctx_i  (rda_ctx),
        .addr_i (rda_addr),
        .data_o (rda_data)
    );

    ctx_read_port #(
        .DATA_W   (DATA_W),
        .NUM_CTX  (NUM_CTX),
        .NUM_REGS (NUM_REGS)
    ) rdb_i (
        .regs_i (regs_w),
        .sp_i   (sp_w),
        .tgt_i  (reg_tgt_e'(rdb_sp)),
        .ctx_i  (rdb_ctx),
        .addr_i (rdb_addr),
        .data_o (rdb_data)
    );

    // A general write is visible on port A in the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sp) |=>
            (rda_sp || (rda_ctx != $past(wr_ctx)) || (rda_addr != $past(wr_addr))
             || (rda_data == $past(wr_data))));

    // A stack-pointer write never reaches a general register
    p_sp_spares_gpr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sp) |=> $stable(regs_w));

    if (SP_SHARED) begin : g_shared_chk
        // Any two contexts see the same stack pointer
        p_sp_common_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rda_sp && rdb_sp) |-> (rda_data == rdb_data));
    end

endmodule

// File: tb/ctx_regbank_tb.sv
module ctx_regbank_tb_top;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sp = 1'b0;
    logic [1:0]    wr_ctx = '0, wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rda_sp = 1'b0, rdb_sp = 1'b0;
    logic [1:0]    rda_ctx = '0, rda_addr = '0, rdb_ctx = '0, rdb_addr = '0;
    logic [DW-1:0] rda_data, rdb_data, sh_rda_data, sh_rdb_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ctx_regbank #(.SP_SHARED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sp(wr_sp),
        .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_data(wr_data),
        .rda_sp(rda_sp), .rda_ctx(rda_ctx), .rda_addr(rda_addr), .rda_data(rda_data),
        .rdb_sp(rdb_sp), .rdb_ctx(rdb_ctx), .rdb_addr(rdb_addr), .rdb_data(rdb_data)
    );

    ctx_regbank #(.SP_SHARED(1'b1)) dut_sh_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sp(wr_sp),
        .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_data(wr_data),
        .rda_sp(rda_sp), .rda_ctx(rda_ctx), .rda_addr(rda_addr), .rda_data(sh_rda_data),
        .rdb_sp(rdb_sp), .rdb_ctx(rdb_ctx), .rdb_addr(rdb_addr), .rdb_data(sh_rdb_data)
    );

    typedef struct packed {
        logic          we;
        logic          sp;
        logic [1:0]    wc;
        logic [1:0]    wa;
        logic [DW-1:0] wd;
        logic          asp;
        logic [1:0]    ac;
        logic [1:0]    aa;
        logic          bsp;
        logic [1:0]    bc;
        logic [1:0]    ba;
        logic [DW-1:0] ea;
        logic [DW-1:0] eb;
        logic [7:0]    rq;
    } vec_t;

    // Reads are sampled before the edge that commits the row's write
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,2'd0,2'd1,32'h11, 1'b0,2'd0,2'd1, 1'b0,2'd2,2'd3, 32'h0,  32'h0,  8'd6},  // R6
        '{1'b1,1'b0,2'd1,2'd1,32'h22, 1'b0,2'd0,2'd1, 1'b0,2'd1,2'd1, 32'h11, 32'h0,  8'd2},  // R2
        '{1'b1,1'b0,2'd2,2'd1,32'h33, 1'b0,2'd1,2'd1, 1'b0,2'd3,2'd1, 32'h22, 32'h0,  8'd3},  // R3
        '{1'b0,1'b0,2'd0,2'd1,32'hFF, 1'b0,2'd2,2'd1, 1'b0,2'd0,2'd1, 32'h33, 32'h11, 8'd3},  // R3
        '{1'b1,1'b0,2'd3,2'd0,32'h44, 1'b0,2'd0,2'd1, 1'b0,2'd3,2'd2, 32'h11, 32'h0,  8'd4},  // R4
        '{1'b1,1'b1,2'd1,2'd1,32'h5A, 1'b0,2'd3,2'd0, 1'b0,2'd1,2'd1, 32'h44, 32'h22, 8'd5},  // R5
        '{1'b1,1'b1,2'd2,2'd1,32'h6B, 1'b1,2'd1,2'd3, 1'b0,2'd1,2'd1, 32'h5A, 32'h22, 8'd8},  // R8
        '{1'b0,1'b0,2'd0,2'd0,32'h0,  1'b1,2'd2,2'd3, 1'b1,2'd0,2'd3, 32'h6B, 32'h0,  8'd8},  // R8
        '{1'b1,1'b0,2'd1,2'd3,32'h77, 1'b0,2'd0,2'd3, 1'b0,2'd2,2'd1, 32'h0,  32'h33, 8'd7},  // R7
        '{1'b0,1'b0,2'd0,2'd0,32'h0,  1'b0,2'd1,2'd3, 1'b1,2'd1,2'd0, 32'h77, 32'h5A, 8'd10}, // R10
        '{1'b1,1'b0,2'd0,2'd1,32'h99, 1'b0,2'd0,2'd1, 1'b1,2'd3,2'd0, 32'h11, 32'h0,  8'd6},  // R6
        '{1'b0,1'b0,2'd0,2'd0,32'h0,  1'b0,2'd0,2'd1, 1'b0,2'd1,2'd1, 32'h99, 32'h22, 8'd2}   // R2
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_write();
        wr_en = 1'b0; wr_sp = 1'b0; wr_ctx = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic set_reads(input logic asp, input logic [1:0] ac, input logic [1:0] aa,
                             input logic bsp, input logic [1:0] bc, input logic [1:0] ba);
        rda_sp = asp; rda_ctx = ac; rda_addr = aa;
        rdb_sp = bsp; rdb_ctx = bc; rdb_addr = ba;
    endtask

    // R1: every register of every context reads zero
    task automatic check_all_zero(input string tag);
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 4; a++) begin
                @(negedge clk);
                set_reads(1'b0, 2'(c), 2'(a), 1'b1, 2'(c), 2'(a));
                #2;
                check(tag, rda_data, '0);
                check(tag, sh_rda_data, '0);
                if (a == 0) begin
                    check(tag, rdb_data, '0);
                    check(tag, sh_rdb_data, '0);
                end
            end
        end
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_write();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        check_all_zero("R1 reset");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_sp = VECS[i].sp; wr_ctx = VECS[i].wc;
            wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
            set_reads(VECS[i].asp, VECS[i].ac, VECS[i].aa, VECS[i].bsp, VECS[i].bc, VECS[i].ba);
            #2;
            check($sformatf("R%0d vec%0d portA", VECS[i].rq, i), rda_data, VECS[i].ea);
            check($sformatf("R%0d vec%0d portB", VECS[i].rq, i), rdb_data, VECS[i].eb);
        end

        // R9: shared copy holds the last stack-pointer write (0x6B from context 2)
        @(negedge clk);
        idle_write();
        set_reads(1'b1, 2'd0, 2'd0, 1'b1, 2'd3, 2'd2);
        #2;
        check("R9 shared sp ctx0", sh_rda_data, 32'h6B);
        check("R9 shared sp ctx3", sh_rdb_data, 32'h6B);
        check("R8 repl sp ctx0", rda_data, 32'h0);

        // R9 and R8: write sp through context 3, read through context 1
        @(negedge clk);
        wr_en = 1'b1; wr_sp = 1'b1; wr_ctx = 2'd3; wr_addr = 2'd2; wr_data = 32'hC3;
        @(negedge clk);
        idle_write();
        set_reads(1'b1, 2'd1, 2'd0, 1'b1, 2'd3, 2'd0);
        #2;
        check("R9 shared sp via ctx1", sh_rda_data, 32'hC3);
        check("R8 repl sp ctx1 kept", rda_data, 32'h5A);
        check("R8 repl sp ctx3", rdb_data, 32'hC3);
        // R10: ignored address of the sp write holds its old general value
        set_reads(1'b0, 2'd3, 2'd2, 1'b0, 2'd0, 2'd1);
        #2;
        check("R10 gpr after sp write", rda_data, 32'h0);
        check("R10 shared gpr intact", sh_rdb_data, 32'h99);

        // R4: disabled write with sp selected changes nothing
        @(negedge clk);
        wr_en = 1'b0; wr_sp = 1'b1; wr_ctx = 2'd1; wr_data = 32'hDEAD;
        @(negedge clk);
        idle_write();
        set_reads(1'b1, 2'd1, 2'd0, 1'b1, 2'd1, 2'd0);
        #2;
        check("R4 sp held", rda_data, 32'h5A);
        check("R4 shared sp held", sh_rdb_data, 32'hC3);

        // R1: reset in the middle of operation clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all_zero("R1 mid-run reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule